// File: doc/BRIEF.md
# Immediate Extension Prefix Unit

This decode-stage unit serves a processor whose instructions are all 16 bits wide while its datapath is 32 bits. A dedicated prefix instruction, marked by a 2-bit opcode, carries 14 immediate bits. The unit stores them in a private extension register rather than in any general-purpose register. Ordinary and prefix instructions share one instruction stream, and no mode switch is needed.

When the next ordinary instruction arrives, the unit combines the held bits with that instruction's 8-bit short immediate to build a full 32-bit operand. Without a pending prefix, the short immediate is sign-extended instead. Several prefixes in a row chain into the register, so that wider constants can be built from more than one prefix.

Each word is accepted only when its valid strobe is high. A flush discards the word on the bus and all prefix state. The outputs are combinational from the current word and the held state, so they are ready in the same cycle for the stage that reads them.

Top module: `imm_prefix_unit`

## Requirements
- R1: An active-low asynchronous reset clears the pending flag and the extension register at once. An ordinary word presented during or right after reset gets a sign-extended immediate, and `imm_ext_o` is low.
- R2: A word is a prefix when bits [15:14] equal 2'b11. For a valid, unflushed prefix word, `prefix_o` is high, `imm_o` is zero and `imm_ext_o` is low.
- R3: An ordinary word with no prefix pending yields `imm_o` equal to its bits [7:0] sign-extended to 32 bits, with `imm_ext_o` low.
- R4: An ordinary word that follows one prefix yields `imm_o` equal to the prefix's 14 bits (bits [13:0]) shifted left by 8, OR-ed with the word's bits [7:0], and `imm_ext_o` is high. Bits [13:8] of the ordinary word do not affect the result.
- R5: Back-to-back prefixes chain. Each one shifts the register left by 14 and appends its 14 bits. The consuming word's result is (register << 8) | bits [7:0], truncated to 32 bits.
- R6: The ordinary word that uses a pending extension clears the pending flag, so the next ordinary word is sign-extended again.
- R7: In a cycle with `instr_valid_i` low, the word on the bus is ignored. All outputs are zero or low, and the pending state and register are held unchanged.
- R8: `flush_i` clears the pending flag and the register at the next clock edge and discards the current word. During a flush cycle, `imm_o` is zero and `prefix_o` and `imm_ext_o` are low.
- R9: Consuming an extension also clears the register contents, so a later single prefix carries no bits from an earlier chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard the current word and all prefix state |
| instr_valid_i | input | 1 | Current instruction word is valid |
| instr_i | input | 16 | Instruction word |
| imm_o | output | 32 | Formed immediate operand |
| imm_ext_o | output | 1 | Immediate was built from the extension register |
| prefix_o | output | 1 | Current word was taken as a prefix |

## Verification
A wrong internal state shows up only on the next ordinary word, because the unit has no status port. A lost or stale pending flag flips `imm_ext_o` and replaces the merged value with a sign-extended one, or the other way round, in the very cycle that word is presented. Bad register contents, such as a missed shift, leftover chain bits or a flush that did not clear, appear in the upper 24 bits of `imm_o` on that same consuming word. The vector sequence therefore always follows each prefix, idle gap, flush or reset with an ordinary word whose expected value depends on the exact bits held.

// File: rtl/imm_prefix_pkg.sv
package imm_prefix_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned OPC_W   = 2;
  localparam int unsigned SHORT_W = 8;
  localparam int unsigned EXT_W   = INSTR_W - OPC_W;
  localparam logic [OPC_W-1:0] EXT_OPC = 2'b11;

  typedef enum logic [1:0] {
    WORD_IDLE,
    WORD_PREFIX,
    WORD_CONSUME,
    WORD_FLUSH
  } word_kind_e;
endpackage

// File: rtl/ipu_field_decode.sv
module ipu_field_decode #(
  parameter int unsigned INSTR_W = imm_prefix_pkg::INSTR_W,
  parameter int unsigned OPC_W   = imm_prefix_pkg::OPC_W,
  parameter int unsigned SHORT_W = imm_prefix_pkg::SHORT_W,
  parameter logic [OPC_W-1:0] EXT_OPC = imm_prefix_pkg::EXT_OPC,
  localparam int unsigned EXT_W  = INSTR_W - OPC_W
) (
  input  logic                 valid_i,
  input  logic                 flush_i,
  input  logic [INSTR_W-1:0]   instr_i,
  output imm_prefix_pkg::word_kind_e kind_o,
  output logic [EXT_W-1:0]     ext_bits_o,
  output logic [SHORT_W-1:0]   short_imm_o
);
  import imm_prefix_pkg::*;

  logic opc_match;

  assign opc_match   = (instr_i[INSTR_W-1 -: OPC_W] == EXT_OPC);
  assign ext_bits_o  = instr_i[EXT_W-1:0];
  assign short_imm_o = instr_i[SHORT_W-1:0];

  // flush overrides every other classification
  always_comb begin
    if (flush_i)       kind_o = WORD_FLUSH;
    else if (!valid_i) kind_o = WORD_IDLE;
    else if (opc_match) kind_o = WORD_PREFIX;
    else               kind_o = WORD_CONSUME;
  end
endmodule

// File: rtl/ipu_ext_reg.sv
module ipu_ext_reg #(
  parameter int unsigned EXT_W  = imm_prefix_pkg::EXT_W,
  parameter int unsigned DATA_W = imm_prefix_pkg::DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  imm_prefix_pkg::word_kind_e kind_i,
  input  logic [EXT_W-1:0]           bits_i,
  output logic [DATA_W-1:0]          ext_q_o,
  output logic                       pend_q_o
);
  import imm_prefix_pkg::*;

  logic [DATA_W-1:0] ext_q, ext_chain;
  logic              pend_q;

  generate
    if (DATA_W > EXT_W) begin : g_chain
      assign ext_chain = {ext_q[DATA_W-EXT_W-1:0], bits_i};
    end else begin : g_trunc
      assign ext_chain = bits_i[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      unique case (kind_i)
        WORD_FLUSH, WORD_CONSUME: begin
          ext_q  <= '0;
          pend_q <= 1'b0;
        end
        WORD_PREFIX: begin
          ext_q  <= ext_chain;
          pend_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ext_q_o  = ext_q;
  assign pend_q_o = pend_q;

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == WORD_IDLE |=> $stable(ext_q) && $stable(pend_q));
  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == WORD_FLUSH |=> !pend_q && ext_q == '0);
  assert_prefix_pends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == WORD_PREFIX |=> pend_q);
  assert_consume_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == WORD_CONSUME |=> !pend_q && ext_q == '0);
endmodule

// File: rtl/ipu_imm_merge.sv
module ipu_imm_merge #(
  parameter int unsigned DATA_W  = imm_prefix_pkg::DATA_W,
  parameter int unsigned SHORT_W = imm_prefix_pkg::SHORT_W
) (
  input  imm_prefix_pkg::word_kind_e kind_i,
  input  logic                       pend_i,
  input  logic [DATA_W-1:0]          ext_i,
  input  logic [SHORT_W-1:0]         short_i,
  output logic [DATA_W-1:0]          imm_o,
  output logic                       imm_ext_o
);
  import imm_prefix_pkg::*;

  logic [DATA_W-1:0] sext_val, merge_val;

  assign sext_val  = {{(DATA_W-SHORT_W){short_i[SHORT_W-1]}}, short_i};
  assign merge_val = (ext_i << SHORT_W) | {{(DATA_W-SHORT_W){1'b0}}, short_i};

  always_comb begin
    imm_o     = '0;
    imm_ext_o = 1'b0;
    if (kind_i == WORD_CONSUME) begin
      imm_ext_o = pend_i;
      imm_o     = pend_i ? merge_val : sext_val;
    end
  end
endmodule

// File: rtl/imm_prefix_unit.sv
module imm_prefix_unit #(
  parameter int unsigned INSTR_W = imm_prefix_pkg::INSTR_W,
  parameter int unsigned DATA_W  = imm_prefix_pkg::DATA_W,
  parameter int unsigned OPC_W   = imm_prefix_pkg::OPC_W,
  parameter int unsigned SHORT_W = imm_prefix_pkg::SHORT_W,
  localparam int unsigned EXT_W  = INSTR_W - OPC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [DATA_W-1:0]  imm_o,
  output logic               imm_ext_o,
  output logic               prefix_o
);
  import imm_prefix_pkg::*;

  word_kind_e         kind;
  logic [EXT_W-1:0]   ext_bits;
  logic [SHORT_W-1:0] short_imm;
  logic [DATA_W-1:0]  ext_q;
  logic               pend_q;

  ipu_field_decode #(
    .INSTR_W(INSTR_W), .OPC_W(OPC_W), .SHORT_W(SHORT_W), .EXT_OPC(EXT_OPC)
  ) u_decode (
    .valid_i    (instr_valid_i),
    .flush_i    (flush_i),
    .instr_i    (instr_i),
    .kind_o     (kind),
    .ext_bits_o (ext_bits),
    .short_imm_o(short_imm)
  );

  ipu_ext_reg #(.EXT_W(EXT_W), .DATA_W(DATA_W)) u_ext_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kind_i  (kind),
    .bits_i  (ext_bits),
    .ext_q_o (ext_q),
    .pend_q_o(pend_q)
  );

  ipu_imm_merge #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_merge (
    .kind_i   (kind),
    .pend_i   (pend_q),
    .ext_i    (ext_q),
    .short_i  (short_imm),
    .imm_o    (imm_o),
    .imm_ext_o(imm_ext_o)
  );

  assign prefix_o = (kind == WORD_PREFIX);

  assert_prefix_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefix_o |-> imm_o == '0 && !imm_ext_o);
  assert_flush_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> imm_o == '0 && !imm_ext_o && !prefix_o);
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> imm_o == '0 && !imm_ext_o && !prefix_o);
  assert_plain_sext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !flush_i && !prefix_o && !pend_q) |->
      ($countones(imm_o[DATA_W-1:SHORT_W-1]) == 0 ||
       $countones(imm_o[DATA_W-1:SHORT_W-1]) == DATA_W-SHORT_W+1));
  assert_ext_follows_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_ext_o |-> pend_q && instr_valid_i && !flush_i);
endmodule

// File: tb/imm_prefix_unit_tb_top.sv
`timescale 1ns/1ps
module imm_prefix_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] imm;
  logic        imm_ext, prefix;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  imm_prefix_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush), .instr_valid_i(valid),
    .instr_i(instr), .imm_o(imm), .imm_ext_o(imm_ext), .prefix_o(prefix)
  );

  // {req[55:52], flush, valid, instr[15:0], imm[31:0], ext, pre}
  localparam int NV = 25;
  localparam logic [55:0] VEC [NV] = '{
    {4'd3, 1'b0, 1'b1, 16'h0005, 32'h00000005, 1'b0, 1'b0}, // R3 positive
    {4'd3, 1'b0, 1'b1, 16'h00F0, 32'hFFFFFFF0, 1'b0, 1'b0}, // R3 negative
    {4'd2, 1'b0, 1'b1, 16'hE345, 32'h00000000, 1'b0, 1'b1}, // R2 prefix
    {4'd4, 1'b0, 1'b1, 16'h3F12, 32'h00234512, 1'b1, 1'b0}, // R4 merge, [13:8] ignored
    {4'd6, 1'b0, 1'b1, 16'h0080, 32'hFFFFFF80, 1'b0, 1'b0}, // R6 consumed
    {4'd2, 1'b0, 1'b1, 16'hFFFF, 32'h00000000, 1'b0, 1'b1}, // R2
    {4'd2, 1'b0, 1'b1, 16'hC001, 32'h00000000, 1'b0, 1'b1}, // R2 chained
    {4'd5, 1'b0, 1'b1, 16'h40AB, 32'hFFC001AB, 1'b1, 1'b0}, // R5 two-prefix chain
    {4'd7, 1'b0, 1'b0, 16'hC123, 32'h00000000, 1'b0, 1'b0}, // R7 invalid prefix ignored
    {4'd7, 1'b0, 1'b1, 16'h0001, 32'h00000001, 1'b0, 1'b0}, // R7 no pending left
    {4'd2, 1'b0, 1'b1, 16'hC002, 32'h00000000, 1'b0, 1'b1}, // R2
    {4'd9, 1'b0, 1'b1, 16'h0003, 32'h00000203, 1'b1, 1'b0}, // R9 no leftover bits
    {4'd2, 1'b0, 1'b1, 16'hC055, 32'h00000000, 1'b0, 1'b1}, // R2
    {4'd7, 1'b0, 1'b0, 16'h00FF, 32'h00000000, 1'b0, 1'b0}, // R7 idle
    {4'd7, 1'b0, 1'b0, 16'h0000, 32'h00000000, 1'b0, 1'b0}, // R7 idle
    {4'd7, 1'b0, 1'b1, 16'h8000, 32'h00005500, 1'b1, 1'b0}, // R7 held across idle
    {4'd2, 1'b0, 1'b1, 16'hC077, 32'h00000000, 1'b0, 1'b1}, // R2
    {4'd8, 1'b1, 1'b1, 16'h0011, 32'h00000000, 1'b0, 1'b0}, // R8 flush cycle quiet
    {4'd8, 1'b0, 1'b1, 16'h0011, 32'h00000011, 1'b0, 1'b0}, // R8 pending gone
    {4'd8, 1'b1, 1'b1, 16'hC033, 32'h00000000, 1'b0, 1'b0}, // R8 prefix discarded
    {4'd8, 1'b0, 1'b1, 16'h00FF, 32'hFFFFFFFF, 1'b0, 1'b0}, // R8 nothing captured
    {4'd2, 1'b0, 1'b1, 16'hC001, 32'h00000000, 1'b0, 1'b1}, // R2
    {4'd2, 1'b0, 1'b1, 16'hC002, 32'h00000000, 1'b0, 1'b1}, // R2
    {4'd2, 1'b0, 1'b1, 16'hC003, 32'h00000000, 1'b0, 1'b1}, // R2
    {4'd5, 1'b0, 1'b1, 16'h0004, 32'h00800304, 1'b1, 1'b0}  // R5 three-prefix truncation
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input logic [31:0] e_imm, input logic e_ext,
                           input logic e_pre, input int req);
    check(imm, e_imm, req, "imm_o");
    check({31'b0, imm_ext}, {31'b0, e_ext}, req, "imm_ext_o");
    check({31'b0, prefix}, {31'b0, e_pre}, req, "prefix_o");
  endtask

  initial begin
    // R1: ordinary word during reset is sign-extended
    valid = 1'b1;
    instr = 16'h00FF;
    #1;
    check_all(32'hFFFFFFFF, 1'b0, 1'b0, 1);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      flush = VEC[i][51];
      valid = VEC[i][50];
      instr = VEC[i][49:34];
      #1;
      check_all(VEC[i][33:2], VEC[i][1], VEC[i][0], int'(VEC[i][55:52]));
    end

    // R1: asynchronous reset drops a pending prefix immediately
    @(negedge clk);
    flush = 1'b0;
    valid = 1'b1;
    instr = 16'hC00F;
    @(negedge clk);
    instr = 16'h0001;
    rst_ni = 1'b0;
    #1;
    check_all(32'h00000001, 1'b0, 1'b0, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check_all(32'h00000001, 1'b0, 1'b0, 1);
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule